// File: doc/BRIEF.md
# Programmable Periodic Countdown Timer

This block is a reloading countdown timer with its own register file on a simple word-addressed bus. Software sets a reload value, then writes an operation code to the control register. One code copies the reload value into the counter. Another lets the counter step down. Two codes stop it. When the counter passes its last count, it takes the reload value again and sets a raw interrupt flag. The flag is masked to drive the interrupt output and is cleared by writing one to an acknowledge register.

The counter steps at the full base rate (one count per clock, 10 ns at 100 MHz) or at a slower prescaled rate, chosen by a field in the control register. Because the period equals the reload value in ticks, a reload value of 1,000,000 at 100 MHz gives 100 interrupts per second. A separate 32-bit up-counter runs freely at the base rate and can only be read. Bus reads are combinational from the address. Writes are taken on the rising clock edge while the write strobe is high.

Register map (word address): 0 reload value (read/write), 1 control (read/write), 2 current count (read only), 3 interrupt mask (bit 0, read/write), 4 masked status (bit 0, read only), 5 raw status (bit 0, read only), 6 acknowledge (write only, bit 0), 7 free-running count (read only). In the control register, bits [1:0] hold the operation: 0 stop, 1 load, 2 run, 3 stop. Bits [3:2] hold the rate: 0 no ticks, 1 base rate, 2 base rate divided by SLOW_DIV (default 4), 3 no ticks.

Top module: `divtimer`

## Requirements
- R1: While reset is low and just after it, the current count, the reload value, the control register, the mask, the raw and masked status, the free-running count and `irq` are all zero.
- R2: A value written to address 0 reads back from address 0. A value written to address 1 reads back in its low four bits (rate in [3:2], operation in [1:0]).
- R3: Writing operation code 1 (load) copies the reload value into the current count on that write's clock edge and leaves the counter stopped.
- R4: With operation 2 (run) and rate code 1, the count falls by one on every clock. On the tick where the count is 1 or 0, it becomes the reload value and the raw flag sets, so after a load of D the raw flag sets on the D-th clock after the run write.
- R5: With rate code 2, the counter steps once every SLOW_DIV clocks, with the first step SLOW_DIV clocks after the run write. With rate code 0 or 3, the count does not change while running.
- R6: Operation codes 0 and 3 freeze the current count.
- R7: Masked status bit 0 reads as raw flag AND mask bit 0, and `irq` equals that bit.
- R8: Writing 1 to acknowledge bit 0 clears the raw flag, and writing 0 leaves it set. An expiry on the same edge as the acknowledge wins, and the flag stays set.
- R9: Writing a new reload value while running does not disturb the current countdown. The new value is used from the next reload on.
- R10: The free-running count rises by one on every clock after reset, and a write to address 7 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Masked timer interrupt |

## Verification
The hardest case to reach is an acknowledge that lands on the same edge as an expiry. The bench sets up this race by loading a reload value of 1, so that the counter expires on every clock, and then writes the acknowledge while it runs. A second timing-sensitive case is a reload-value write in the middle of a countdown. The bench counts clocks exactly from the run write so that it can sample the count just before and just after the expiry edge.

// File: rtl/divtimer_pkg.sv
package divtimer_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    OP_STOP = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_HALT = 2'd3
  } opCode_e;

  typedef enum logic [1:0] {
    FRQ_OFF  = 2'd0,
    FRQ_BASE = 2'd1,
    FRQ_SLOW = 2'd2,
    FRQ_NONE = 2'd3
  } frqCode_e;

  localparam logic [REG_AW-1:0] ADR_DIV   = 3'd0;
  localparam logic [REG_AW-1:0] ADR_CTRL  = 3'd1;
  localparam logic [REG_AW-1:0] ADR_COUNT = 3'd2;
  localparam logic [REG_AW-1:0] ADR_MASK  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_MSTAT = 3'd4;
  localparam logic [REG_AW-1:0] ADR_RAW   = 3'd5;
  localparam logic [REG_AW-1:0] ADR_ACK   = 3'd6;
  localparam logic [REG_AW-1:0] ADR_FREE  = 3'd7;

  // strobes from register control to the counting datapath
  typedef struct packed {
    logic     load;
    logic     run;
    frqCode_e frq;
    logic     ack;
  } tmrStrobe_t;

endpackage

// File: rtl/divtimer_regs.sv
module divtimer_regs
  import divtimer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  input  logic [DW-1:0]     cntVal,
  input  logic [DW-1:0]     freeVal,
  input  logic              rawIrq,
  output logic [DW-1:0]     divVal,
  output logic              maskBit,
  output tmrStrobe_t        strb
);

  localparam int PAD_W = DW - 4;

  opCode_e  opReg;
  frqCode_e frqReg;
  logic     wrDiv, wrCtrl, wrMask, wrAck;

  assign wrDiv  = busWr && (busAddr == ADR_DIV);
  assign wrCtrl = busWr && (busAddr == ADR_CTRL);
  assign wrMask = busWr && (busAddr == ADR_MASK);
  assign wrAck  = busWr && (busAddr == ADR_ACK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal  <= '0;
      opReg   <= OP_STOP;
      frqReg  <= FRQ_OFF;
      maskBit <= 1'b0;
    end else begin
      if (wrDiv)  divVal  <= busWdata;
      if (wrCtrl) begin
        opReg  <= opCode_e'(busWdata[1:0]);
        frqReg <= frqCode_e'(busWdata[3:2]);
      end
      if (wrMask) maskBit <= busWdata[0];
    end
  end

  always_comb begin
    strb.load = wrCtrl && (opCode_e'(busWdata[1:0]) == OP_LOAD);
    strb.run  = (opReg == OP_RUN);
    strb.frq  = frqReg;
    strb.ack  = wrAck && busWdata[0];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_DIV:   busRdata = divVal;
      ADR_CTRL:  busRdata = {{PAD_W{1'b0}}, frqReg, opReg};
      ADR_COUNT: busRdata = cntVal;
      ADR_MASK:  busRdata = {{(DW-1){1'b0}}, maskBit};
      ADR_MSTAT: busRdata = {{(DW-1){1'b0}}, rawIrq & maskBit};
      ADR_RAW:   busRdata = {{(DW-1){1'b0}}, rawIrq};
      ADR_FREE:  busRdata = freeVal;
      default:   busRdata = '0;
    endcase
  end

  // R2
  div_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDiv |=> divVal == $past(busWdata));

  // R3
  load_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.run);

endmodule

// File: rtl/divtimer_core.sv
module divtimer_core
  import divtimer_pkg::*;
#(
  parameter int DW       = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strb,
  input  logic [DW-1:0] divVal,
  output logic [DW-1:0] cntVal,
  output logic [DW-1:0] freeVal,
  output logic       rawIrq
);

  localparam int PS_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic slowTick, tick, expire;

  generate
    if (SLOW_DIV > 1) begin : g_presc
      logic [PS_W-1:0] psCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                 psCnt <= '0;
        else if (!strb.run || strb.frq != FRQ_SLOW) psCnt <= '0;
        else if (psCnt == PS_W'(SLOW_DIV - 1))     psCnt <= '0;
        else                                       psCnt <= psCnt + 1'b1;
      end
      assign slowTick = (psCnt == PS_W'(SLOW_DIV - 1));
    end else begin : g_nopresc
      assign slowTick = 1'b1;
    end
  endgenerate

  always_comb begin
    case (strb.frq)
      FRQ_BASE: tick = 1'b1;
      FRQ_SLOW: tick = slowTick;
      default:  tick = 1'b0;
    endcase
  end

  assign expire = strb.run && tick && !strb.load && (cntVal <= DW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
      rawIrq <= 1'b0;
    end else begin
      if (strb.load)               cntVal <= divVal;
      else if (expire)             cntVal <= divVal;
      else if (strb.run && tick)   cntVal <= cntVal - 1'b1;
      if (expire)                  rawIrq <= 1'b1;
      else if (strb.ack)           rawIrq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freeVal <= '0;
    else       freeVal <= freeVal + 1'b1;
  end

  // R4
  expiry_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.frq == FRQ_BASE && !strb.load && cntVal <= DW'(1))
      |=> (rawIrq && cntVal == $past(divVal)));

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.load) |=> $stable(cntVal));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && !strb.run) |=> !rawIrq);

  // R10
  free_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> freeVal == $past(freeVal) + 1'b1);

endmodule

// File: rtl/divtimer.sv
module divtimer
  import divtimer_pkg::*;
#(
  parameter int DW       = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  output logic              irq
);

  tmrStrobe_t    strb;
  logic [DW-1:0] divVal, cntVal, freeVal;
  logic          rawIrq, maskBit;

  divtimer_regs #(.DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cntVal(cntVal),
    .freeVal(freeVal), .rawIrq(rawIrq), .divVal(divVal),
    .maskBit(maskBit), .strb(strb)
  );

  divtimer_core #(.DW(DW), .SLOW_DIV(SLOW_DIV)) u_core (
    .clk(clk), .rstN(rstN), .strb(strb), .divVal(divVal),
    .cntVal(cntVal), .freeVal(freeVal), .rawIrq(rawIrq)
  );

  assign irq = rawIrq & maskBit;

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskBit |-> !irq);

endmodule

// File: tb/tb_divtimer.sv
module tb_divtimer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWr;
  logic [2:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        irq;
  int          nRun = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  divtimer dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // control words: rate in [3:2], operation in [1:0]
  localparam logic [31:0] C_STOP  = 32'h4;
  localparam logic [31:0] C_LOAD  = 32'h5;
  localparam logic [31:0] C_RUN   = 32'h6;
  localparam logic [31:0] C_SLOAD = 32'h9;
  localparam logic [31:0] C_SRUN  = 32'hA;
  localparam logic [31:0] C_ORUN  = 32'h2;

  // vector table: reload value, load word, run word, clocks to expiry
  localparam int NV = 4;
  localparam int          V_DIV [NV] = '{5, 3, 1, 2};
  localparam logic [31:0] V_LD  [NV] = '{C_LOAD, C_LOAD, C_LOAD, C_SLOAD};
  localparam logic [31:0] V_RN  [NV] = '{C_RUN, C_RUN, C_RUN, C_SRUN};
  localparam int          V_EXP [NV] = '{5, 3, 1, 8};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] v, f1, f2;
    rstN = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd2, v); check("R1 count", v, 0);
    rd(3'd0, v); check("R1 reload", v, 0);
    rd(3'd1, v); check("R1 control", v, 0);
    rd(3'd5, v); check("R1 raw", v, 0);
    rd(3'd4, v); check("R1 masked", v, 0);
    rd(3'd7, v); check("R1 free", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R2 readback
    wr(3'd0, 32'h1234_5678); rd(3'd0, v); check("R2 reload", v, 32'h1234_5678);
    wr(3'd1, 32'hFFFF_FFF9); rd(3'd1, v); check("R2 control", v, 32'h9);
    @(negedge clk);

    // vector walk: R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, C_STOP);
      wr(3'd6, 32'h1);
      wr(3'd0, V_DIV[i]);
      wr(3'd1, V_LD[i]);
      rd(3'd2, v); check("R3 loaded count", v, V_DIV[i]);
      rd(3'd5, v); check("R3 raw after load", v, 0);
      wr(3'd1, V_RN[i]);
      repeat (V_EXP[i] - 1) @(negedge clk);
      rd(3'd2, v); check(i == 3 ? "R5 last count" : "R4 last count", v, 1);
      rd(3'd5, v); check(i == 3 ? "R5 raw early" : "R4 raw early", v, 0);
      @(negedge clk);
      rd(3'd5, v); check(i == 3 ? "R5 raw at expiry" : "R4 raw at expiry", v, 1);
      rd(3'd2, v); check(i == 3 ? "R5 reload" : "R4 reload", v, V_DIV[i]);
    end

    // R9 reload write mid-countdown
    wr(3'd1, C_STOP); wr(3'd6, 32'h1);
    wr(3'd0, 32'd10); wr(3'd1, C_LOAD); wr(3'd1, C_RUN);
    repeat (2) @(negedge clk);
    wr(3'd0, 32'd3);
    rd(3'd2, v); check("R9 count undisturbed", v, 7);
    repeat (6) @(negedge clk);
    rd(3'd2, v); check("R9 count before expiry", v, 1);
    rd(3'd5, v); check("R9 raw before expiry", v, 0);
    @(negedge clk);
    rd(3'd5, v); check("R9 raw at expiry", v, 1);
    rd(3'd2, v); check("R9 new reload", v, 3);
    wr(3'd1, C_STOP);

    // R7 mask
    rd(3'd4, v); check("R7 masked off", v, 0);
    check("R7 irq off", {31'd0, irq}, 0);
    wr(3'd3, 32'h1);
    rd(3'd4, v); check("R7 masked on", v, 1);
    check("R7 irq on", {31'd0, irq}, 1);

    // R8 acknowledge
    wr(3'd6, 32'h0); rd(3'd5, v); check("R8 ack zero keeps", v, 1);
    wr(3'd6, 32'h1); rd(3'd5, v); check("R8 ack clears", v, 0);
    check("R8 irq cleared", {31'd0, irq}, 0);
    wr(3'd0, 32'd1); wr(3'd1, C_LOAD); wr(3'd1, C_RUN);
    wr(3'd6, 32'h1); rd(3'd5, v); check("R8 expiry beats ack", v, 1);
    wr(3'd1, C_STOP); wr(3'd6, 32'h1);
    rd(3'd5, v); check("R8 ack after stop", v, 0);

    // R6 stop freezes
    wr(3'd0, 32'd20); wr(3'd1, C_LOAD); wr(3'd1, C_RUN);
    repeat (3) @(negedge clk);
    wr(3'd1, C_STOP);
    rd(3'd2, f1);
    repeat (5) @(negedge clk);
    rd(3'd2, v); check("R6 frozen count", v, f1);
    check("R6 count moved", f1, 16);
    wr(3'd1, 32'h7);
    repeat (3) @(negedge clk);
    rd(3'd2, v); check("R6 code 3 frozen", v, 16);

    // R5 rate off
    wr(3'd1, C_ORUN);
    repeat (5) @(negedge clk);
    rd(3'd2, v); check("R5 rate off holds", v, 16);

    // R10 free-running count
    rd(3'd7, f1);
    repeat (7) @(negedge clk);
    rd(3'd7, f2); check("R10 step", f2 - f1, 7);
    wr(3'd7, 32'h0);
    rd(3'd7, v); check("R10 write ignored", v, f2 + 1);

    summary();
  end

endmodule